// File: doc/BRIEF.md
# Serial Flash Write-Protection Guard

This block rules on whether a modifying command in a serial flash device may go ahead. A modifying command is a page program, a sector erase, a whole-array erase or a status-register write. While chip select is low, the block counts the rising edges of the serial clock. When chip select returns high, it weighs three things together: the block-protect code, the hardware lock made of the status-register write-disable bit and the write-protect pin, and whether the clock count is a multiple of eight. One clock cycle later it raises either an execute strobe or a reject strobe, for exactly one cycle.

The array is 2 MB and is split into 32 sectors of 64 KB. The block-protect code selects a protected window that grows downward from the top of the array. Reads are never judged here. Command decoding, the write-enable latch and the array operation belong to neighbouring logic. Those blocks present the command class, the target address and the protection settings, and they hold these stable until the verdict. `serial clock` and `chip select` arrive already synchronous to `clk`.

The controller has three states. `ST_IDLE` means deselected. `ST_SHIFT` means selected and counting. `ST_VERDICT` is the one-cycle strobe slot. The transitions are:
- `ST_IDLE`→`ST_SHIFT` when chip select is sampled low.
- `ST_SHIFT`→`ST_VERDICT` when chip select is sampled high, which also latches the decision.
- `ST_VERDICT`→`ST_IDLE` when chip select is high.
- `ST_VERDICT`→`ST_SHIFT` when chip select is already low again.

Top module: `fwp_guard`

## Requirements
- R1: While reset is asserted, and after it until the first verdict, `exec_o` and `reject_o` are both low.
- R2: For command classes 1 to 4, a frame produces exactly one strobe, either `exec_o` or `reject_o` and never both. It is high for a single cycle, in the cycle after the first clock edge that samples `cs_n` high following the frame.
- R3: Command class 0 (no modifying command) and classes 5 to 7 produce no strobe.
- R4: If the number of `sck` rising edges counted during the frame is not a multiple of eight, any class 1 to 4 command is rejected. The count stays correct beyond the counter's range, for example at 257 or 264 edges.
- R5: The protected window is set by `bp`. Code 0 protects nothing. Codes 1 to 5 protect the top 1, 2, 4, 8 and 16 sectors: from 1F0000h, 1E0000h, 1C0000h, 180000h and 100000h respectively, up to 1FFFFFh. A program whose target address lies in the window is rejected, and one below it executes.
- R6: `bp` codes 6 and 7 protect the whole array, so every program and sector erase is rejected.
- R7: A sector erase (class 2) is judged on the 64 KB sector holding its address. The offset inside the sector does not matter.
- R8: A whole-array erase (class 3) executes only when `bp` is 0.
- R9: A status-register write (class 4) is rejected exactly when `srwd` is 1 and `wp_n` is 0, whatever `bp` holds.
- R10: The pulse count restarts at every new selection. Edges from an earlier frame do not carry into the next one.
- R11: `sck` edges while `cs_n` is high are not counted.
- R12: Only address bits 20:16 select the sector. Bits 23:21 and 15:0 do not affect the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| sck | input | 1 | Serial clock level, sampled by clk |
| cmd_cls | input | 3 | Command class: 0 none, 1 program, 2 sector erase, 3 whole-array erase, 4 status write |
| bp | input | BP_W (3) | Block-protect code |
| srwd | input | 1 | Status-register write-disable bit |
| wp_n | input | 1 | Write-protect pin, active low |
| addr | input | ADDR_W (24) | Target byte address |
| exec_o | output | 1 | One-cycle strobe: command may execute |
| reject_o | output | 1 | One-cycle strobe: command is refused |

## Verification
The bench builds the block with its default parameters: a 24-bit address, 64 KB sectors, 32 sectors, a 3-bit protect code and an 8-bit pulse counter. The 8-bit counter lets the bench run frames of 257 and 264 edges, which wrap the counter, so the multiple-of-eight rule is checked across that wrap. With 32 sectors, every protect code from the empty window to the full array can be reached, and addresses just inside and just outside each window edge are exercised. Aliased upper address bits are also covered.

// File: rtl/fwp_pkg.sv
package fwp_pkg;

    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_PROG = 3'd1,
        CMD_SECT = 3'd2,
        CMD_BULK = 3'd3,
        CMD_SRWR = 3'd4
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SHIFT   = 2'd1,
        ST_VERDICT = 2'd2
    } st_e;

    // Sectors covered by a protect code, counted from the top of the array.
    function automatic int prot_count(input int code, input int aw);
        if (code == 0)
            return 0;
        if (code - 1 >= aw)
            return 1 << aw;
        return 1 << (code - 1);
    endfunction

endpackage

// File: rtl/fwp_pulse_count.sv
module fwp_pulse_count #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic en,
    input  logic sck,
    output logic aligned
);

    logic             sck_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rise;

    assign rise = sck & ~sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
        end else begin
            sck_q <= sck;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (en && rise) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign aligned = (cnt_q[2:0] == 3'b000);

    // R10: a cleared counter starts the next frame at zero
    a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

    // R11: without enable the count does not move
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/fwp_window.sv
module fwp_window #(
    parameter int SECT_AW = 5,
    parameter int BP_W    = 3
) (
    input  logic [BP_W-1:0]    bp,
    input  logic [SECT_AW-1:0] sect_idx,
    output logic               hit,
    output logic               bp_any
);
    import fwp_pkg::*;

    localparam int NCODES  = 1 << BP_W;
    localparam int SECTORS = 1 << SECT_AW;

    logic [SECT_AW:0] lo_tab [NCODES];

    for (genvar g = 0; g < NCODES; g++) begin : g_lo
        localparam int LO = SECTORS - prot_count(g, SECT_AW);
        assign lo_tab[g] = LO[SECT_AW:0];
    end

    assign hit    = ({1'b0, sect_idx} >= lo_tab[bp]);
    assign bp_any = |bp;

endmodule

// File: rtl/fwp_rules.sv
module fwp_rules (
    input  logic [2:0] cls,
    input  logic       aligned,
    input  logic       win_hit,
    input  logic       bp_any,
    input  logic       srwd,
    input  logic       wp_n,
    output logic       valid,
    output logic       pass
);
    import fwp_pkg::*;

    logic lock;

    always_comb begin
        valid = 1'b1;
        lock  = 1'b0;
        case (cls)
            CMD_PROG, CMD_SECT: lock = win_hit;
            CMD_BULK:           lock = bp_any;
            CMD_SRWR:           lock = srwd & ~wp_n;
            default:            valid = 1'b0;
        endcase
        pass = valid & aligned & ~lock;
    end

endmodule

// File: rtl/fwp_guard.sv
module fwp_guard #(
    parameter int ADDR_W     = 24,
    parameter int SECT_SHIFT = 16,
    parameter int SECT_AW    = 5,
    parameter int BP_W       = 3,
    parameter int CNT_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic [2:0]        cmd_cls,
    input  logic [BP_W-1:0]   bp,
    input  logic              srwd,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              exec_o,
    output logic              reject_o
);
    import fwp_pkg::*;

    localparam int SECT_TOP = SECT_SHIFT + SECT_AW;

    st_e  state_q, state_d;
    logic cnt_en, cnt_clr, aligned;
    logic win_hit, bp_any;
    logic dec_valid, dec_pass;
    logic valid_q, pass_q;
    logic [SECT_AW-1:0] sect_idx;
    logic unused_addr_bits;

    assign sect_idx         = addr[SECT_SHIFT +: SECT_AW];
    assign unused_addr_bits = ^{addr[ADDR_W-1:SECT_TOP], addr[SECT_SHIFT-1:0]};

    assign cnt_en  = (state_q == ST_SHIFT) && !cs_n;
    assign cnt_clr = (state_q != ST_SHIFT);

    fwp_pulse_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cnt_clr),
        .en      (cnt_en),
        .sck     (sck),
        .aligned (aligned)
    );

    fwp_window #(.SECT_AW(SECT_AW), .BP_W(BP_W)) u_window (
        .bp       (bp),
        .sect_idx (sect_idx),
        .hit      (win_hit),
        .bp_any   (bp_any)
    );

    fwp_rules u_rules (
        .cls     (cmd_cls),
        .aligned (aligned),
        .win_hit (win_hit),
        .bp_any  (bp_any),
        .srwd    (srwd),
        .wp_n    (wp_n),
        .valid   (dec_valid),
        .pass    (dec_pass)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (!cs_n) state_d = ST_SHIFT;
            ST_SHIFT:   if (cs_n)  state_d = ST_VERDICT;
            ST_VERDICT: state_d = cs_n ? ST_IDLE : ST_SHIFT;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register and decision latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            valid_q <= 1'b0;
            pass_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SHIFT && cs_n) begin
                valid_q <= dec_valid;
                pass_q  <= dec_pass;
            end
        end
    end

    // outputs
    always_comb begin
        exec_o   = 1'b0;
        reject_o = 1'b0;
        if (state_q == ST_VERDICT && valid_q) begin
            exec_o   = pass_q;
            reject_o = ~pass_q;
        end
    end

    // R2: never both strobes
    a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_o && reject_o));

    // R2: a strobe lasts one cycle
    a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o || reject_o) |=> !(exec_o || reject_o));

    // R2: a strobe follows a sampled release of chip select
    a_r2_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o || reject_o) |-> $past(cs_n));

    // R4: an executed command had an aligned pulse count
    a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        exec_o |-> aligned);

    // R5: code 0 opens no window
    a_r5_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (bp == '0) |-> !win_hit);

    // R6: codes 6 and 7 cover every sector
    a_r6_full: assert property (@(posedge clk) disable iff (!rst_n)
        (bp >= BP_W'(6)) |-> win_hit);

endmodule

// File: tb/fwp_guard_tb.sv
module fwp_guard_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n;
    logic        sck;
    logic [2:0]  cmd_cls;
    logic [2:0]  bp;
    logic        srwd;
    logic        wp_n;
    logic [23:0] addr;
    logic        exec_o;
    logic        reject_o;

    always #4 clk = ~clk;

    fwp_guard u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .cmd_cls  (cmd_cls),
        .bp       (bp),
        .srwd     (srwd),
        .wp_n     (wp_n),
        .addr     (addr),
        .exec_o   (exec_o),
        .reject_o (reject_o)
    );

    // expected kinds: 0 no strobe, 1 execute, 2 reject
    typedef struct {
        int    kind;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   armed = 1'b0;
    bit   ended = 1'b0;

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    function automatic int model(input logic [2:0] c, input logic [2:0] b,
                                 input logic s, input logic w,
                                 input logic [23:0] a, input int np);
        int lo;
        int sec;
        if (c == 3'd0 || c > 3'd4)
            return 0;
        if (np % 8 != 0)
            return 2;
        case (b)
            3'd0: lo = 32;
            3'd1: lo = 31;
            3'd2: lo = 30;
            3'd3: lo = 28;
            3'd4: lo = 24;
            3'd5: lo = 16;
            default: lo = 0;
        endcase
        sec = int'(a[20:16]);
        case (c)
            3'd1, 3'd2: return (sec >= lo) ? 2 : 1;
            3'd3:       return (b != 3'd0) ? 2 : 1;
            default:    return (s && !w) ? 2 : 1;
        endcase
    endfunction

    task automatic frame(input logic [2:0] c, input logic [2:0] b,
                         input logic s, input logic w, input logic [23:0] a,
                         input int np, input int pre, input string tag);
        exp_t e;
        cmd_cls = c;
        bp      = b;
        srwd    = s;
        wp_n    = w;
        addr    = a;
        for (int i = 0; i < pre; i++) begin
            sck = 1'b1; step(1);
            sck = 1'b0; step(1);
        end
        cs_n = 1'b0;
        step(2);
        for (int i = 0; i < np; i++) begin
            sck = 1'b1; step(1);
            sck = 1'b0; step(1);
        end
        step(1);
        cs_n   = 1'b1;
        e.kind = model(c, b, s, w, a, np);
        e.tag  = tag;
        q.push_back(e);
        step(3);
    endtask

    // monitor: compare one cycle after release
    always @(negedge clk) begin
        int got;
        if (!ended) begin
            if (q.size() > 0) begin
                if (armed) begin
                    got = (exec_o && reject_o) ? 3 : exec_o ? 1 : reject_o ? 2 : 0;
                    n_cmp++;
                    if (got != q[0].kind) begin
                        n_bad++;
                        $display("FAIL %s: strobe kind actual %0d expected %0d",
                                 q[0].tag, got, q[0].kind);
                    end
                    void'(q.pop_front());
                    armed = 1'b0;
                end else begin
                    armed = 1'b1;
                end
            end else if (rst_n && (exec_o || reject_o)) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R2: stray strobe actual exec=%0b reject=%0b expected 0/0",
                         exec_o, reject_o);
            end
        end
    end

    task automatic finish_run();
        ended = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run actual hung expected finished");
        finish_run();
    end

    initial begin
        rst_n   = 1'b0;
        cs_n    = 1'b1;
        sck     = 1'b0;
        cmd_cls = 3'd0;
        bp      = 3'd0;
        srwd    = 1'b0;
        wp_n    = 1'b1;
        addr    = 24'h0;
        step(3);
        n_cmp++;
        if (exec_o || reject_o) begin
            n_bad++;
            $display("FAIL R1: in reset actual %0b/%0b expected 0/0", exec_o, reject_o);
        end
        rst_n = 1'b1;
        step(3);
        n_cmp++;
        if (exec_o || reject_o) begin
            n_bad++;
            $display("FAIL R1: after reset actual %0b/%0b expected 0/0", exec_o, reject_o);
        end

        // R5 window edges
        frame(3'd1, 3'd0, 1'b0, 1'b1, 24'h1F0000, 8,  0, "R5 bp0 top");
        frame(3'd1, 3'd1, 1'b0, 1'b1, 24'h1F0000, 8,  0, "R5 bp1 in");
        frame(3'd1, 3'd1, 1'b0, 1'b1, 24'h1EFFFF, 16, 0, "R5 bp1 below");
        frame(3'd1, 3'd2, 1'b0, 1'b1, 24'h1E0000, 8,  0, "R5 bp2 in");
        frame(3'd1, 3'd3, 1'b0, 1'b1, 24'h1C0000, 8,  0, "R5 bp3 in");
        frame(3'd1, 3'd3, 1'b0, 1'b1, 24'h1BFFFF, 8,  0, "R5 bp3 below");
        frame(3'd1, 3'd4, 1'b0, 1'b1, 24'h180000, 8,  0, "R5 bp4 in");
        frame(3'd1, 3'd4, 1'b0, 1'b1, 24'h17FFFF, 8,  0, "R5 bp4 below");
        frame(3'd1, 3'd5, 1'b0, 1'b1, 24'h100000, 8,  0, "R5 bp5 in");
        frame(3'd1, 3'd5, 1'b0, 1'b1, 24'h0FFFFF, 8,  0, "R5 bp5 below");
        // R6 whole array
        frame(3'd1, 3'd6, 1'b0, 1'b1, 24'h000000, 8,  0, "R6 bp6");
        frame(3'd2, 3'd7, 1'b0, 1'b1, 24'h000010, 8,  0, "R6 bp7 erase");
        // R7 sector erase
        frame(3'd2, 3'd1, 1'b0, 1'b1, 24'h1F8000, 8,  0, "R7 mid sector");
        frame(3'd2, 3'd2, 1'b0, 1'b1, 24'h1DFFFF, 8,  0, "R7 below window");
        // R8 whole-array erase
        frame(3'd3, 3'd0, 1'b0, 1'b1, 24'h000000, 8,  0, "R8 bp0");
        frame(3'd3, 3'd4, 1'b0, 1'b1, 24'h000000, 8,  0, "R8 bp4");
        // R9 hardware lock
        frame(3'd4, 3'd0, 1'b1, 1'b0, 24'h000000, 8,  0, "R9 locked");
        frame(3'd4, 3'd7, 1'b1, 1'b1, 24'h000000, 16, 0, "R9 pin high");
        frame(3'd4, 3'd0, 1'b0, 1'b0, 24'h000000, 8,  0, "R9 srwd clear");
        // R4 pulse count
        frame(3'd1, 3'd0, 1'b0, 1'b1, 24'h000000, 7,   0, "R4 seven");
        frame(3'd1, 3'd0, 1'b0, 1'b1, 24'h000000, 9,   0, "R4 nine");
        frame(3'd4, 3'd0, 1'b0, 1'b1, 24'h000000, 12,  0, "R4 twelve");
        frame(3'd1, 3'd0, 1'b0, 1'b1, 24'h000000, 264, 0, "R4 wrap aligned");
        frame(3'd3, 3'd0, 1'b0, 1'b1, 24'h000000, 257, 0, "R4 wrap odd");
        // R3 no modifying command
        frame(3'd0, 3'd0, 1'b0, 1'b1, 24'h000000, 8,  0, "R3 class0");
        frame(3'd5, 3'd0, 1'b0, 1'b1, 24'h000000, 8,  0, "R3 class5");
        frame(3'd7, 3'd7, 1'b1, 1'b0, 24'h1F0000, 8,  0, "R3 class7");
        // R10 fresh count per frame
        frame(3'd0, 3'd0, 1'b0, 1'b1, 24'h000000, 4,  0, "R10 primer");
        frame(3'd1, 3'd0, 1'b0, 1'b1, 24'h000000, 8,  0, "R10 after four");
        frame(3'd1, 3'd0, 1'b0, 1'b1, 24'h000000, 3,  0, "R10 odd");
        frame(3'd1, 3'd0, 1'b0, 1'b1, 24'h000000, 8,  0, "R10 after odd");
        // R11 edges while deselected
        frame(3'd1, 3'd0, 1'b0, 1'b1, 24'h000000, 8,  3, "R11 pre three");
        frame(3'd4, 3'd0, 1'b0, 1'b1, 24'h000000, 5,  3, "R11 pre plus five");
        // R12 aliased address bits
        frame(3'd1, 3'd1, 1'b0, 1'b1, 24'h3F0000, 8,  0, "R12 alias top");
        frame(3'd1, 3'd5, 1'b0, 1'b1, 24'h200000, 8,  0, "R12 alias low");
        frame(3'd2, 3'd1, 1'b0, 1'b1, 24'hE1FFFF, 8,  0, "R12 alias high bits");

        step(4);
        finish_run();
    end

endmodule